// File: doc/BRIEF.md
# Multi-Bank Interrupt Request Aggregator

This block gathers up to 73 asynchronous interrupt request lines, coming from peripherals and from general-purpose input pins, and condenses them into two processor request outputs. One is a fast request (FIQ) and one is a normal request (IRQ). Each line is brought into the clock domain through a two-stage synchroniser. The lines are split across banks of 32, so the default build has three banks and the last bank holds nine live lines. Each bank keeps four settings per line:

- an enable;
- a polarity bit;
- a kind bit that selects level or edge detection;
- a route bit that selects FIQ or IRQ.

Software uses a flat register port with one write strobe and a registered read value. Through this port it programs the settings, reads each line's raw detected state and its enabled (masked) state, and clears latched edge events by writing ones. Vectoring and priority resolution are left to whatever sits downstream. The two outputs are plain registered wire-ORs of the masked lines routed to each.

Top module: `irq_hub`

## Requirements
- R1: After reset, all of the following hold: every enable and route bit reads 0 (all lines to IRQ); every kind bit reads 0 (level); every polarity bit of a live line reads 1; both `fiq` and `irq` are low.
- R2: A line whose enable bit is 0 never drives `fiq` or `irq`. Its raw status bit still shows its detected state.
- R3: With kind=0 and polarity=1 (active-high level), the raw status bit equals the synchronised input.
- R4: With kind=0 and polarity=0 (active-low level), the raw status bit equals the inverse of the synchronised input.
- R5: With kind=1 and polarity=1, a 0-to-1 transition of the synchronised input sets the raw bit. The bit stays set after the input falls.
- R6: With kind=1 and polarity=0, a 1-to-0 transition sets the raw bit. A rise leaves it clear.
- R7: Writing the raw status register clears each edge-kind bit whose data bit is 1. Data bits of 0 have no effect. Level-kind bits are not affected. An edge that arrives in the same cycle as its clear leaves the bit set.
- R8: `fiq` is high when any line has both masked status and route bit set to 1. `irq` is high when any line has masked status 1 and route bit 0. Both outputs are registered.
- R9: The masked status register reads raw status ANDed with the enables.
- R10: The address is split so that `addr[4:3]` selects the bank (0 to 2) and `addr[2:0]` selects the register:
  - 0 = enable
  - 1 = raw status
  - 2 = masked status
  - 3 = polarity
  - 4 = kind
  - 5 = route

  `rd_data` shows the addressed register one clock after the address is applied. Bank 3, register codes 6 and 7, and bit positions with no live line all read 0. Writes to these, and writes to masked status, are ignored.
- R11: For a level line, a change at `src` reaches `fiq`/`irq` on the third rising clock edge after the change. For an edge line, the change reaches the output on the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 73 | Asynchronous interrupt request lines; line n lives in bank n/32, bit n%32 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Bank select in bits 4:3, register select in bits 2:0 |
| wr_data | input | 32 | Write data, one bit per line of the selected bank |
| rd_data | output | 32 | Registered read data of the addressed register |
| fiq | output | 1 | Fast interrupt request |
| irq | output | 1 | Normal interrupt request |

## Verification
The bench puts a pulse on an edge line and lets it end before software reads the line. A design that tracked the level instead of latching would read 0. Clear writes are tested with zero data, and also against level lines. A design that cleared on any write, or that zeroed level bits, shows a raw value that differs from the expected one. A clear is timed to land in the same cycle as a new edge; a design that let the clear win would lose that event. The bench also probes the partial third bank, the nonexistent fourth bank and the read-only masked register, where a sloppy decoder would leak or store bits. It measures output latency to the exact edge, so a missing or extra synchroniser stage shows up as an early or late request.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int BANK_W    = 32;
  localparam int REG_SEL_W = 3;

  typedef enum logic [REG_SEL_W-1:0] {
    REG_EN    = 3'd0,
    REG_RAW   = 3'd1,
    REG_MASK  = 3'd2,
    REG_POL   = 3'd3,
    REG_KIND  = 3'd4,
    REG_ROUTE = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign q_out = stage2_q;
endmodule

// File: rtl/irq_hub_trig.sv
module irq_hub_trig #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev_q, prev_nxt;
  logic [W-1:0] latch_q, latch_nxt;
  logic [W-1:0] hit;

  // Edge detection against the previous synchronised sample; set beats clear.
  always_comb begin
    hit       = kind & ((pol & s_in & ~prev_q) | (~pol & ~s_in & prev_q));
    latch_nxt = ((latch_q & ~clr) | hit) & kind;
    prev_nxt  = s_in;
    raw       = (kind & latch_q) | (~kind & ~(s_in ^ pol));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= prev_nxt;
      latch_q <= latch_nxt;
    end
  end
endmodule

// File: rtl/irq_hub_bank.sv
module irq_hub_bank
  import irq_hub_pkg::*;
#(
  parameter int LIVE = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_SEL_W-1:0] reg_sel,
  input  logic [BANK_W-1:0]    wdata,
  input  logic [BANK_W-1:0]    sync_in,
  output logic [BANK_W-1:0]    rd_val,
  output logic [BANK_W-1:0]    en_o,
  output logic [BANK_W-1:0]    raw_o,
  output logic [BANK_W-1:0]    mask_o,
  output logic [BANK_W-1:0]    kind_o,
  output logic [BANK_W-1:0]    route_o,
  output logic                 fiq_req,
  output logic                 irq_req
);
  localparam logic [BANK_W-1:0] LIVE_MASK = BANK_W'((64'd1 << LIVE) - 64'd1);

  logic [BANK_W-1:0] en_q, pol_q, kind_q, route_q;
  logic [BANK_W-1:0] cfg_nxt;
  logic              we_en, we_pol, we_kind, we_route;
  logic [BANK_W-1:0] clr;
  logic [BANK_W-1:0] raw_det;
  reg_sel_e          sel;

  always_comb begin
    sel      = reg_sel_e'(reg_sel);
    cfg_nxt  = wdata & LIVE_MASK;
    we_en    = wr_en && (sel == REG_EN);
    we_pol   = wr_en && (sel == REG_POL);
    we_kind  = wr_en && (sel == REG_KIND);
    we_route = wr_en && (sel == REG_ROUTE);
    clr      = (wr_en && (sel == REG_RAW)) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pol_q   <= LIVE_MASK;
      kind_q  <= '0;
      route_q <= '0;
    end else begin
      if (we_en)    en_q    <= cfg_nxt;
      if (we_pol)   pol_q   <= cfg_nxt;
      if (we_kind)  kind_q  <= cfg_nxt;
      if (we_route) route_q <= cfg_nxt;
    end
  end

  irq_hub_trig #(.W(BANK_W)) u_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .s_in  (sync_in),
    .pol   (pol_q),
    .kind  (kind_q),
    .clr   (clr),
    .raw   (raw_det)
  );

  always_comb begin
    raw_o   = raw_det & LIVE_MASK;
    mask_o  = raw_o & en_q;
    en_o    = en_q;
    kind_o  = kind_q;
    route_o = route_q;
    fiq_req = |(mask_o & route_q);
    irq_req = |(mask_o & ~route_q);
    unique case (sel)
      REG_EN:    rd_val = en_q;
      REG_RAW:   rd_val = raw_o;
      REG_MASK:  rd_val = mask_o;
      REG_POL:   rd_val = pol_q;
      REG_KIND:  rd_val = kind_q;
      REG_ROUTE: rd_val = route_q;
      default:   rd_val = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter  int NUM_SRC  = 73,
  localparam int NUM_BANK = (NUM_SRC + BANK_W - 1) / BANK_W,
  localparam int BSEL_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int ADDR_W   = BSEL_W + REG_SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BANK_W-1:0]  wr_data,
  output logic [BANK_W-1:0]  rd_data,
  output logic               fiq,
  output logic               irq
);
  localparam int TOT_W = NUM_BANK * BANK_W;

  logic [NUM_SRC-1:0]   src_s;
  logic [TOT_W-1:0]     src_pad;
  logic [BSEL_W-1:0]    bank_sel;
  logic [REG_SEL_W-1:0] reg_sel;
  logic [BANK_W-1:0]    rd_val [NUM_BANK];
  logic [NUM_BANK-1:0]  fiq_vec, irq_vec;
  logic [TOT_W-1:0]     en_all, raw_all, mask_all, kind_all, route_all;
  logic [BANK_W-1:0]    rd_nxt, rd_q;
  logic                 fiq_nxt, irq_nxt, fiq_q, irq_q;

  irq_hub_sync #(.W(NUM_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (src),
    .q_out (src_s)
  );

  assign src_pad  = TOT_W'(src_s);
  assign bank_sel = addr[ADDR_W-1:REG_SEL_W];
  assign reg_sel  = addr[REG_SEL_W-1:0];

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam int LIVE = ((NUM_SRC - b * BANK_W) >= BANK_W) ? BANK_W
                                                             : (NUM_SRC - b * BANK_W);
    logic bank_wr;
    assign bank_wr = wr_en && (bank_sel == BSEL_W'(b));

    irq_hub_bank #(.LIVE(LIVE)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr),
      .reg_sel (reg_sel),
      .wdata   (wr_data),
      .sync_in (src_pad[b*BANK_W +: BANK_W]),
      .rd_val  (rd_val[b]),
      .en_o    (en_all[b*BANK_W +: BANK_W]),
      .raw_o   (raw_all[b*BANK_W +: BANK_W]),
      .mask_o  (mask_all[b*BANK_W +: BANK_W]),
      .kind_o  (kind_all[b*BANK_W +: BANK_W]),
      .route_o (route_all[b*BANK_W +: BANK_W]),
      .fiq_req (fiq_vec[b]),
      .irq_req (irq_vec[b])
    );
  end

  always_comb begin
    rd_nxt = '0;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (bank_sel == BSEL_W'(b)) rd_nxt = rd_val[b];
    end
    fiq_nxt = |fiq_vec;
    irq_nxt = |irq_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      fiq_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rd_q  <= rd_nxt;
      fiq_q <= fiq_nxt;
      irq_q <= irq_nxt;
    end
  end

  assign rd_data = rd_q;
  assign fiq     = fiq_q;
  assign irq     = irq_q;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter  int NUM_SRC  = 73,
  localparam int NUM_BANK = (NUM_SRC + BANK_W - 1) / BANK_W,
  localparam int BSEL_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int TOT_W    = NUM_BANK * BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [BSEL_W-1:0] bank_sel,
  input logic [BANK_W-1:0] rd_data,
  input logic              fiq,
  input logic              irq,
  input logic [TOT_W-1:0]  raw_all,
  input logic [TOT_W-1:0]  mask_all,
  input logic [TOT_W-1:0]  kind_all,
  input logic [TOT_W-1:0]  route_all
);
  // R1: requests stay low while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!fiq && !irq));

  // R8: fast request follows the masked lines routed to it, one cycle later
  a_r8_fiq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fiq == $past(|(mask_all & route_all)));

  // R8: normal request follows the masked lines routed to it, one cycle later
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(mask_all & ~route_all)));

  // R7: without a write, a latched edge bit of an edge-kind line never drops
  a_r7_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ((($past(raw_all) & $past(kind_all) & kind_all) & ~raw_all) == '0));

  // R10: a nonexistent bank reads as zero
  a_r10_bad_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'($past(bank_sel)) >= NUM_BANK) |-> (rd_data == '0));
endmodule

bind irq_hub irq_hub_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .bank_sel  (addr[ADDR_W-1:irq_hub_pkg::REG_SEL_W]),
  .rd_data   (rd_data),
  .fiq       (fiq),
  .irq       (irq),
  .raw_all   (raw_all),
  .mask_all  (mask_all),
  .kind_all  (kind_all),
  .route_all (route_all)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  localparam int NSRC = 73;
  localparam logic [2:0] R_EN = 3'd0, R_RAW = 3'd1, R_MASK = 3'd2,
                         R_POL = 3'd3, R_KIND = 3'd4, R_ROUTE = 3'd5;

  typedef struct {
    int          kind;   // 0 rd_data, 1 fiq, 2 irq
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic            clk, rst_n, wr_en, fiq, irq;
  logic [NSRC-1:0] src;
  logic [4:0]      addr;
  logic [31:0]     wr_data, rd_data;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;

  irq_hub uut (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .fiq(fiq), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [4:0] ra(input int bank, input logic [2:0] r);
    return {2'(bank), r};
  endfunction

  // Monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = (it.kind == 0) ? rd_data : (it.kind == 1) ? {31'd0, fiq} : {31'd0, irq};
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    @(posedge clk); #1;
    push(0, exp, tag);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_src(input int idx, input logic v);
    @(negedge clk);
    src[idx] = v;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0; src = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk_rd(ra(0, R_EN),    32'h0,        "R1 enable b0");
    chk_rd(ra(0, R_POL),   32'hFFFF_FFFF,"R1 polarity b0");
    chk_rd(ra(2, R_POL),   32'h0000_01FF,"R1 polarity b2 live lines");
    chk_rd(ra(1, R_ROUTE), 32'h0,        "R1 route b1");
    chk_rd(ra(0, R_KIND),  32'h0,        "R1 kind b0");
    push(1, 0, "R1 fiq low"); push(2, 0, "R1 irq low");

    // R3 active-high level on line 5
    wr(ra(0, R_EN), 32'h20);
    set_src(5, 1); wait_cyc(4);
    push(2, 1, "R3 irq on high level"); push(1, 0, "R8 fiq idle for irq line");
    chk_rd(ra(0, R_RAW),  32'h20, "R3 raw follows high");
    chk_rd(ra(0, R_MASK), 32'h20, "R9 masked enabled");
    set_src(5, 0); wait_cyc(4);
    push(2, 0, "R3 irq drops with level");
    chk_rd(ra(0, R_RAW), 32'h0, "R3 raw follows low");

    // R2 disabled line
    wr(ra(0, R_EN), 32'h0);
    set_src(5, 1); wait_cyc(4);
    chk_rd(ra(0, R_RAW),  32'h20, "R2 raw visible when disabled");
    chk_rd(ra(0, R_MASK), 32'h0,  "R2 masked zero when disabled");
    push(2, 0, "R2 irq quiet when disabled");
    set_src(5, 0); wait_cyc(4);

    // R8 routing line 40 to fiq
    wr(ra(1, R_ROUTE), 32'h100);
    wr(ra(1, R_EN),    32'h100);
    set_src(40, 1); wait_cyc(4);
    push(1, 1, "R8 fiq from routed line"); push(2, 0, "R8 irq stays low");
    set_src(40, 0); wait_cyc(4);
    push(1, 0, "R8 fiq released");
    wr(ra(1, R_EN), 32'h0);

    // R4 active-low level on line 70
    wr(ra(2, R_POL), 32'h1BF); wait_cyc(1);
    chk_rd(ra(2, R_RAW), 32'h40, "R4 raw set by low input");
    wr(ra(2, R_EN), 32'h40); wait_cyc(3);
    push(2, 1, "R4 irq on low level");
    set_src(70, 1); wait_cyc(4);
    push(2, 0, "R4 irq off on high input");
    chk_rd(ra(2, R_RAW), 32'h0, "R4 raw clear on high input");
    wr(ra(2, R_EN), 32'h0); wr(ra(2, R_POL), 32'h1FF); set_src(70, 0);
    wait_cyc(4);

    // R11 level latency
    wr(ra(0, R_EN), 32'h20);
    set_src(5, 1);
    wait_cyc(2); push(2, 0, "R11 level not yet after two edges");
    wait_cyc(1); push(2, 1, "R11 level seen on third edge");
    set_src(5, 0); wait_cyc(4);
    wr(ra(0, R_EN), 32'h0);

    // R5 rising edge on line 12, with R11 edge latency
    wr(ra(0, R_KIND), 32'h1000);
    wr(ra(0, R_EN),   32'h1000);
    set_src(12, 1);
    wait_cyc(3); push(2, 0, "R11 edge not yet after three edges");
    wait_cyc(1); push(2, 1, "R11 edge seen on fourth edge");
    set_src(12, 0); wait_cyc(4);
    chk_rd(ra(0, R_RAW), 32'h1000, "R5 edge latched after input falls");
    push(2, 1, "R5 irq held by latch");

    // R7 clear behaviour
    wr(ra(0, R_RAW), 32'h0); wait_cyc(1);
    chk_rd(ra(0, R_RAW), 32'h1000, "R7 zero write keeps latch");
    wr(ra(0, R_RAW), 32'h1000); wait_cyc(3);
    push(2, 0, "R7 irq drops after clear");
    chk_rd(ra(0, R_RAW), 32'h0, "R7 latch cleared");
    set_src(5, 1); wait_cyc(4);
    wr(ra(0, R_RAW), 32'hFFFF_FFFF);
    chk_rd(ra(0, R_RAW), 32'h20, "R7 level bit immune to clear");
    set_src(5, 0); wait_cyc(4);
    set_src(12, 1);
    @(posedge clk); @(posedge clk);
    wr(ra(0, R_RAW), 32'h1000);
    chk_rd(ra(0, R_RAW), 32'h1000, "R7 edge beats simultaneous clear");
    set_src(12, 0); wait_cyc(4);
    wr(ra(0, R_RAW), 32'h1000);
    wr(ra(0, R_EN), 32'h0); wr(ra(0, R_KIND), 32'h0);

    // R6 falling edge on line 33
    wr(ra(1, R_POL),  32'hFFFF_FFFD);
    wr(ra(1, R_KIND), 32'h2);
    set_src(33, 1); wait_cyc(4);
    chk_rd(ra(1, R_RAW), 32'h0, "R6 rise ignored");
    set_src(33, 0); wait_cyc(4);
    chk_rd(ra(1, R_RAW), 32'h2, "R6 fall latched");
    wr(ra(1, R_EN), 32'h2); wait_cyc(3);
    push(2, 1, "R6 irq from falling edge"); push(1, 0, "R8 fiq low for irq route");
    wr(ra(1, R_RAW), 32'h2); wr(ra(1, R_EN), 32'h0);

    // R10 decode corners
    chk_rd(ra(3, R_EN), 32'h0, "R10 bank 3 reads zero");
    chk_rd({2'd0, 3'd6}, 32'h0, "R10 code 6 reads zero");
    wr(ra(0, R_MASK), 32'hFFFF_FFFF);
    wr(ra(3, R_EN),   32'hFFFF_FFFF);
    chk_rd(ra(0, R_EN), 32'h0, "R10 masked write ignored");
    chk_rd(ra(1, R_EN), 32'h0, "R10 bank 3 write ignored b1");
    chk_rd(ra(2, R_EN), 32'h0, "R10 bank 3 write ignored b2");
    wr(ra(2, R_EN), 32'hFFFF_FFFF);
    chk_rd(ra(2, R_EN), 32'h1FF, "R10 dead lines not stored");
    @(negedge clk) src = '1;
    wait_cyc(4);
    chk_rd(ra(2, R_RAW), 32'h1FF, "R10 raw dead lines zero");
    chk_rd(ra(1, R_RAW), 32'hFFFF_FFFD, "R3 bank-wide high levels");
    push(2, 1, "R8 irq from bank 2");
    wr(ra(2, R_EN), 32'h0F);
    chk_rd(ra(2, R_MASK), 32'h0F, "R9 partial enable mask");
    @(negedge clk) src = '0;
    wr(ra(2, R_EN), 32'h0);
    wait_cyc(4);
    push(2, 0, "R2 all disabled irq low");
    push(1, 0, "R2 all disabled fiq low");

    wait_cyc(2);
    done = 1;
    finish_run();
  end
endmodule